// File: doc/BRIEF.md
# Genlocked Frame-Start Controller

This block decides when each display frame begins. In free-running mode it passes on the local timing generator's frame-start pulse. In locked mode it waits for a vertical sync from an external video source. After that sync it counts a programmable skew delay and then issues its own single-cycle frame-start pulse. If the timeout fallback is enabled and no external sync arrives in time, the block issues the pulse by itself. The local display can therefore follow an incoming video stream and still keep running when that stream stops.

Three status outputs show the block's state. The first is high while the skew delay is counting. The second shows whether the latest frame was started by the external sync or by the timeout. The third is a synchronized copy of the source's stream-valid indication. The control settings are double buffered. A software-side update request only arms them, and they move into the active set on the next output frame-start pulse, so a frame never runs with a mix of old and new settings.

Top module: `vsync_lock_ctrl`

## Requirements
- R1: When locked mode is active with skew S > 0, the external sync passes two synchronizer flops and a rising-edge detector, and `stat_skew_wait` rises on the third clock edge after `ext_vsync` is first sampled high.
- R2: In locked mode, `vsync_out` is a one-cycle pulse that rises on clock edge S+3 counted from the edge that first samples `ext_vsync` high. For S = 0 this is the cycle after the synchronized edge. `stat_skew_wait` falls on that same edge.
- R3: `stat_lock_active` becomes 1 when a pulse on `vsync_out` was caused by the external sync. While the mode stays locked it changes only on edges where `vsync_out` rises.
- R4: With the timeout fallback enabled and timeout value T > 0, a self-generated pulse comes T+1 cycles after the previous pulse when no external sync arrives. That pulse clears `stat_lock_active`. With the fallback disabled, no pulse is generated without an external sync.
- R5: In free-running mode the external sync has no effect, `vsync_out` repeats `local_frame_start` one cycle later, and `stat_lock_active` reads 0. In locked mode `local_frame_start` has no effect.
- R6: `stat_video_ok` follows `ext_video_ok` through a two-flop synchronizer. It changes on the second clock edge after the input changes.
- R7: A `cfg_update` pulse arms the `cfg_*` inputs. They become active on the first `vsync_out` pulse at or after the request. The pulse that applies them still uses the old settings.
- R8: An external sync rising edge that arrives while `stat_skew_wait` is high is dropped. It neither restarts the delay nor causes a second pulse.
- R9: Synchronous reset clears all outputs and loads an active configuration of free-running mode, fallback off, skew 0 and timeout 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lock_en | input | 1 | Staged setting: 1 selects locked mode |
| cfg_tmo_en | input | 1 | Staged setting: 1 enables the timeout fallback |
| cfg_skew | input | SKEW_W | Staged skew delay in cycles |
| cfg_tmo | input | TMO_W | Staged timeout value in cycles (0 disables the fallback) |
| cfg_update | input | 1 | Request to apply the staged settings at the next frame start |
| ext_vsync | input | 1 | Asynchronous external vertical sync |
| ext_video_ok | input | 1 | Asynchronous valid-stream indication from the source |
| local_frame_start | input | 1 | Free-running local frame-start pulse |
| vsync_out | output | 1 | Frame-start pulse |
| stat_skew_wait | output | 1 | Skew delay counting |
| stat_lock_active | output | 1 | Latest frame was started by the external sync |
| stat_video_ok | output | 1 | Synchronized valid-stream indication |

## Verification
If the skew counter is in the wrong state, the skew latency sweep sees `vsync_out` land on the wrong cycle within S+3 cycles of the sync. `stat_skew_wait` also falls out of step with the pulse. A timeout counter that is not cleared on each pulse makes the fallback period differ from T+1 within a single frame. If the pending-update flag or the active configuration is wrong, the next one or two pulses show the wrong skew or the wrong mode. A stuck source flag shows up in `stat_lock_active` on the very next pulse.

// File: rtl/vlk_pkg.sv
package vlk_pkg;

    typedef enum logic [1:0] {
        SRC_LOCAL   = 2'd0,
        SRC_EXT     = 2'd1,
        SRC_TIMEOUT = 2'd2
    } frame_src_e;

    typedef struct packed {
        logic       fire;
        frame_src_e src;
    } frame_req_t;

    function automatic frame_req_t mk_req(input logic f, input frame_src_e s);
        frame_req_t r;
        r.fire = f;
        r.src  = s;
        return r;
    endfunction

endpackage

// File: rtl/vlk_sync2.sv
module vlk_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_in;
            stab_q <= meta_q;
        end
    end

    assign sync_out = stab_q;
endmodule

// File: rtl/vlk_cfg_hold.sv
module vlk_cfg_hold #(
    parameter int SKEW_W = 8,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stg_lock_en,
    input  logic              stg_tmo_en,
    input  logic [SKEW_W-1:0] stg_skew,
    input  logic [TMO_W-1:0]  stg_tmo,
    input  logic              upd_req,
    input  logic              frame_next,
    output logic              act_lock_en,
    output logic              act_tmo_en,
    output logic [SKEW_W-1:0] act_skew,
    output logic [TMO_W-1:0]  act_tmo
);
    logic pend_q;
    logic apply;

    assign apply = frame_next & (pend_q | upd_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            act_lock_en <= 1'b0;
            act_tmo_en  <= 1'b0;
            act_skew    <= '0;
            act_tmo     <= '0;
        end else begin
            if (apply) begin
                pend_q      <= 1'b0;
                act_lock_en <= stg_lock_en;
                act_tmo_en  <= stg_tmo_en;
                act_skew    <= stg_skew;
                act_tmo     <= stg_tmo;
            end else if (upd_req) begin
                pend_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/vlk_skew_timer.sv
module vlk_skew_timer #(
    parameter int SKEW_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock_en,
    input  logic              sync_lvl,
    input  logic [SKEW_W-1:0] skew,
    output logic              skew_wait,
    output logic              skew_fire,
    output logic              edge_acc
);
    localparam logic [SKEW_W-1:0] SKEW_ZERO = '0;

    logic              lvl_d;
    logic              wait_q;
    logic [SKEW_W-1:0] cnt_q;
    logic              rise;

    always_ff @(posedge clk) begin
        if (rst) lvl_d <= 1'b0;
        else     lvl_d <= sync_lvl;
    end

    assign rise      = sync_lvl & ~lvl_d;
    assign edge_acc  = lock_en & rise & ~wait_q;
    assign skew_fire = lock_en & ((edge_acc & (skew == SKEW_ZERO)) |
                                  (wait_q & (cnt_q == SKEW_ZERO)));

    always_ff @(posedge clk) begin
        if (rst || !lock_en) begin
            wait_q <= 1'b0;
            cnt_q  <= '0;
        end else if (edge_acc && skew != SKEW_ZERO) begin
            wait_q <= 1'b1;
            cnt_q  <= skew - 1'b1;
        end else if (wait_q) begin
            if (cnt_q == SKEW_ZERO) wait_q <= 1'b0;
            else                    cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign skew_wait = wait_q;
endmodule

// File: rtl/vlk_frame_gen.sv
module vlk_frame_gen
    import vlk_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lock_en,
    input  logic             tmo_en,
    input  logic [TMO_W-1:0] tmo,
    input  logic             skew_fire,
    input  logic             skew_wait,
    input  logic             edge_acc,
    input  logic             local_fs,
    output logic             frame_next,
    output logic             vs_out,
    output logic             lock_src
);
    localparam logic [TMO_W-1:0] TCNT_MAX = '1;
    localparam logic [TMO_W-1:0] TMO_ZERO = '0;

    logic [TMO_W-1:0] tcnt_q;
    logic             tmo_hit;
    frame_req_t       req;

    assign tmo_hit = lock_en & tmo_en & (tmo != TMO_ZERO) & ~skew_wait &
                     ~edge_acc & (tcnt_q == tmo);

    always_comb begin
        if (!lock_en)       req = mk_req(local_fs, SRC_LOCAL);
        else if (skew_fire) req = mk_req(1'b1, SRC_EXT);
        else if (tmo_hit)   req = mk_req(1'b1, SRC_TIMEOUT);
        else                req = mk_req(1'b0, SRC_LOCAL);
    end

    assign frame_next = req.fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_out   <= 1'b0;
            tcnt_q   <= '0;
            lock_src <= 1'b0;
        end else begin
            vs_out <= req.fire;
            if (req.fire)                tcnt_q <= '0;
            else if (tcnt_q != TCNT_MAX) tcnt_q <= tcnt_q + 1'b1;
            if (!lock_en)      lock_src <= 1'b0;
            else if (req.fire) lock_src <= (req.src == SRC_EXT);
        end
    end
endmodule

// File: rtl/vsync_lock_ctrl.sv
module vsync_lock_ctrl #(
    parameter int SKEW_W = 8,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_lock_en,
    input  logic              cfg_tmo_en,
    input  logic [SKEW_W-1:0] cfg_skew,
    input  logic [TMO_W-1:0]  cfg_tmo,
    input  logic              cfg_update,
    input  logic              ext_vsync,
    input  logic              ext_video_ok,
    input  logic              local_frame_start,
    output logic              vsync_out,
    output logic              stat_skew_wait,
    output logic              stat_lock_active,
    output logic              stat_video_ok
);
    localparam int NSYNC = 2;

    logic [NSYNC-1:0]  sync_v;
    logic              lk_en;
    logic              to_en;
    logic [SKEW_W-1:0] skew_a;
    logic [TMO_W-1:0]  tmo_a;
    logic              frame_next;
    logic              skew_fire;
    logic              edge_acc;
    logic              lock_src;

    vlk_sync2 #(.W(NSYNC)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({ext_video_ok, ext_vsync}),
        .sync_out (sync_v)
    );

    vlk_cfg_hold #(.SKEW_W(SKEW_W), .TMO_W(TMO_W)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .stg_lock_en (cfg_lock_en),
        .stg_tmo_en  (cfg_tmo_en),
        .stg_skew    (cfg_skew),
        .stg_tmo     (cfg_tmo),
        .upd_req     (cfg_update),
        .frame_next  (frame_next),
        .act_lock_en (lk_en),
        .act_tmo_en  (to_en),
        .act_skew    (skew_a),
        .act_tmo     (tmo_a)
    );

    vlk_skew_timer #(.SKEW_W(SKEW_W)) u_skew (
        .clk       (clk),
        .rst       (rst),
        .lock_en   (lk_en),
        .sync_lvl  (sync_v[0]),
        .skew      (skew_a),
        .skew_wait (stat_skew_wait),
        .skew_fire (skew_fire),
        .edge_acc  (edge_acc)
    );

    vlk_frame_gen #(.TMO_W(TMO_W)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .lock_en    (lk_en),
        .tmo_en     (to_en),
        .tmo        (tmo_a),
        .skew_fire  (skew_fire),
        .skew_wait  (stat_skew_wait),
        .edge_acc   (edge_acc),
        .local_fs   (local_frame_start),
        .frame_next (frame_next),
        .vs_out     (vsync_out),
        .lock_src   (lock_src)
    );

    assign stat_lock_active = lock_src & lk_en;
    assign stat_video_ok    = sync_v[1];
endmodule

// File: rtl/vlk_checker.sv
module vlk_checker (
    input logic clk,
    input logic rst,
    input logic lk_en,
    input logic edge_acc,
    input logic vsync_out,
    input logic stat_skew_wait,
    input logic stat_lock_active
);
    p_skew_rise_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_skew_wait) |-> $past(edge_acc));

    p_skew_end_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_skew_wait) |-> vsync_out);

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        (lk_en && $past(lk_en) && vsync_out) |=> !vsync_out);

    p_lock_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (lk_en && $past(lk_en) && (stat_lock_active != $past(stat_lock_active)))
        |-> vsync_out);

    p_lock_off_r5: assert property (@(posedge clk) disable iff (rst)
        !lk_en |-> !stat_lock_active);
endmodule

bind vsync_lock_ctrl vlk_checker u_chk (
    .clk              (clk),
    .rst              (rst),
    .lk_en            (lk_en),
    .edge_acc         (edge_acc),
    .vsync_out        (vsync_out),
    .stat_skew_wait   (stat_skew_wait),
    .stat_lock_active (stat_lock_active)
);

// File: tb/sim_vsync_lock_ctrl.sv
`timescale 1ns/1ps
module sim_vsync_lock_ctrl;
    localparam int SW = 4;
    localparam int TW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_lock_en = 1'b0, cfg_tmo_en = 1'b0, cfg_update = 1'b0;
    logic [SW-1:0] cfg_skew = '0;
    logic [TW-1:0] cfg_tmo = '0;
    logic          ext_vsync = 1'b0, ext_video_ok = 1'b0, local_frame_start = 1'b0;
    logic          vsync_out, stat_skew_wait, stat_lock_active, stat_video_ok;

    int  n_chk = 0;
    int  n_bad = 0;
    logic cur_en = 1'b0;

    always #10 clk = ~clk;

    vsync_lock_ctrl #(.SKEW_W(SW), .TMO_W(TW)) u0 (
        .clk(clk), .rst(rst),
        .cfg_lock_en(cfg_lock_en), .cfg_tmo_en(cfg_tmo_en),
        .cfg_skew(cfg_skew), .cfg_tmo(cfg_tmo), .cfg_update(cfg_update),
        .ext_vsync(ext_vsync), .ext_video_ok(ext_video_ok),
        .local_frame_start(local_frame_start),
        .vsync_out(vsync_out), .stat_skew_wait(stat_skew_wait),
        .stat_lock_active(stat_lock_active), .stat_video_ok(stat_video_ok)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic wait_vs(output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (!vsync_out && n < 200);
    endtask

    task automatic apply_cfg(input logic en, input logic te, input int sk, input int tm);
        int n;
        cfg_lock_en = en; cfg_tmo_en = te;
        cfg_skew = SW'(sk); cfg_tmo = TW'(tm);
        cfg_update = 1'b1;
        tick();
        cfg_update = 1'b0;
        if (cur_en) ext_vsync = 1'b1; else local_frame_start = 1'b1;
        tick();
        ext_vsync = 1'b0; local_frame_start = 1'b0;
        wait_vs(n);
        cur_en = en;
        idle(40);
    endtask

    // Drive one external sync and return the cycle count at which vsync_out is seen
    task automatic ext_latency(input int sk, output int lat);
        lat = 0;
        ext_vsync = 1'b1;
        do begin
            tick();
            lat++;
            ext_vsync = 1'b0;
            if (sk > 0 && lat == sk + 2) chk("R1 skew_wait during delay", int'(stat_skew_wait), 1);
            if (sk > 0 && lat == 2)      chk("R1 skew_wait before edge", int'(stat_skew_wait), 0);
        end while (!vsync_out && lat < 100);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lat, cnt;
        idle(3);
        // R9 reset state
        chk("R9 vsync_out in reset", int'(vsync_out), 0);
        chk("R9 skew_wait in reset", int'(stat_skew_wait), 0);
        chk("R9 lock_active in reset", int'(stat_lock_active), 0);
        chk("R9 video_ok in reset", int'(stat_video_ok), 0);
        rst = 1'b0;
        idle(2);
        // R9 default active config is free-running: local pulse passes
        local_frame_start = 1'b1;
        tick();
        local_frame_start = 1'b0;
        chk("R9 default free-running pulse", int'(vsync_out), 1);
        tick();
        chk("R9 pulse is single", int'(vsync_out), 0);

        // R6 video ok synchronizer
        ext_video_ok = 1'b1;
        tick(); chk("R6 video_ok after 1 edge", int'(stat_video_ok), 0);
        tick(); chk("R6 video_ok after 2 edges", int'(stat_video_ok), 1);
        ext_video_ok = 1'b0;
        tick(); chk("R6 video_ok fall 1 edge", int'(stat_video_ok), 1);
        tick(); chk("R6 video_ok fall 2 edges", int'(stat_video_ok), 0);

        // R1 R2 R3 skew sweep
        for (int s = 0; s < (1 << SW); s++) begin
            apply_cfg(1'b1, 1'b0, s, 63);
            ext_latency(s, lat);
            chk("R2 latency", lat, s + 3);
            chk("R2 skew_wait clear at pulse", int'(stat_skew_wait), 0);
            chk("R3 lock_active after ext", int'(stat_lock_active), 1);
            tick();
            chk("R2 pulse one cycle", int'(vsync_out), 0);
        end

        // R8 second edge during skew wait
        apply_cfg(1'b1, 1'b0, 8, 63);
        ext_vsync = 1'b1; tick(); ext_vsync = 1'b0;
        idle(4);
        ext_vsync = 1'b1; tick(); ext_vsync = 1'b0;
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (vsync_out) cnt++;
        end
        chk("R8 one pulse for two edges", cnt, 1);
        // R4 no fallback when disabled (no pulse for many cycles)
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            tick();
            if (vsync_out) cnt++;
        end
        chk("R4 no pulse with fallback off", cnt, 0);
        // R5 local pulse ignored in locked mode
        local_frame_start = 1'b1; tick(); local_frame_start = 1'b0;
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (vsync_out) cnt++;
        end
        chk("R5 local ignored when locked", cnt, 0);

        // R4 timeout sweep
        for (int t = 3; t <= 12; t++) begin
            apply_cfg(1'b1, 1'b1, 2, t);
            wait_vs(lat);
            chk("R4 lock_active after timeout", int'(stat_lock_active), 0);
            wait_vs(lat);
            chk("R4 timeout period", lat, t + 1);
        end

        // R7 deferred settings
        apply_cfg(1'b1, 1'b0, 0, 63);
        cfg_skew = SW'(5);
        cfg_update = 1'b1; tick(); cfg_update = 1'b0;
        idle(5);
        ext_latency(0, lat);
        chk("R7 old skew on applying pulse", lat, 3);
        idle(20);
        ext_latency(5, lat);
        chk("R7 new skew after apply", lat, 8);

        // R5 free-running mode
        apply_cfg(1'b0, 1'b0, 0, 0);
        chk("R5 lock_active zero when free", int'(stat_lock_active), 0);
        ext_vsync = 1'b1; tick(); ext_vsync = 1'b0;
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (vsync_out) cnt++;
        end
        chk("R5 ext ignored when free", cnt, 0);
        local_frame_start = 1'b1; tick(); local_frame_start = 1'b0;
        chk("R5 local pulse follows", int'(vsync_out), 1);
        tick();
        chk("R5 local pulse single", int'(vsync_out), 0);
        chk("R5 lock_active still zero", int'(stat_lock_active), 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule